// File: doc/BRIEF.md
# Bit-flip test slice decompressor

This block feeds a set of parallel scan chains with one bit per chain per shift, taking each new horizontal slice as a set of bit inversions applied to the slice held before it. A slice register keeps the current slice from one slice to the next. Scan responses never write back into it; they go to a separate compactor. A single serial test input moves into a short index register on every clock. The new bit enters at the most significant end, and the oldest bit drops off the least significant end. The index register's contents select one slice position through a one-hot decoder. That position is inverted on any clock where the flip enable is high.

Successive indices share most of their bits. Moving from one index to a neighbouring index therefore often needs only one new serial bit, not a full index. The off-chip encoder exploits this by ordering the flips. The flip enable can come from a dedicated pin. It can also come from a pin shared with the test data output, so that no extra pad is needed. A load strobe copies the held slice to a parallel output, with a one-cycle valid flag, for the chains to take.

The output side has no back-pressure. The slice output carries only a valid flag and no ready: the scan chains must take the slice in the cycle the flag is high. The data is overwritten on the next load.

Top module: `slice_flip_decomp`

## Requirements
- R1: A synchronous active-high reset clears the index register and the slice register to all zeros and holds the valid flag low.
- R2: On every clock out of reset, the serial bit enters the most significant bit of the index register. The other bits move down one place. For example, with an 8-bit slice, state 000 followed by input 1 gives index 4 (binary 100).
- R3: When the flip is enabled, exactly one slice bit inverts at that clock edge. The inverted bit is the one numbered by the index register's contents after that same edge's shift.
- R4: When the flip enable is low, the slice register does not change.
- R5: Overlapping indices need only one new bit each. For example, from index 0, shifting in 1 then 1 with the flip enabled on both clocks inverts bits 4 and then 6.
- R6: A load strobe makes the valid flag high for exactly the next cycle. In that cycle the slice output equals the slice register's value from before the strobe's edge. Without a strobe the flag is low.
- R7: No flip takes place on a clock where the load strobe is high, even with the flip enable high. The index register still shifts on that clock.
- R8: The enable source select chooses the enable: 0 takes the dedicated enable pin and 1 takes the shared pin. The pin that is not selected has no effect.
- R9: The slice register holds its value across loads. Inverting the same index twice restores the earlier slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_in | input | 1 | Serial index bit, taken on every clock |
| flip_en | input | 1 | Dedicated flip enable |
| shared_en | input | 1 | Flip enable taken from the shared output pin |
| en_src_shared | input | 1 | 0: use flip_en, 1: use shared_en |
| load_slice | input | 1 | Copy the held slice to the output |
| slice_out | output | SLICE_W | Slice presented to the chains, one bit per chain |
| slice_valid | output | 1 | slice_out is valid this cycle |

## Verification
A wrong index register state shows up as the wrong bit inverted. The error reaches the ports at the next load, one cycle after its strobe. Because the slice is never cleared, it also persists in every later slice. A slice register that changes without an enable, or during a load, shows the same way at the following load. The bench therefore presents a load after every short flip sequence, and it compares every cycle of a long pseudo-random run against an arithmetic model. This keeps the distance between a fault and its detection at a few cycles.

// File: rtl/slice_flip_pkg.sv
package slice_flip_pkg;
  typedef enum logic {EN_SRC_PIN = 1'b0, EN_SRC_SHARED = 1'b1} en_src_e;
endpackage

// File: rtl/sfd_index_shifter.sv
module sfd_index_shifter #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [IDX_W-1:0] idx_next,
  output logic [IDX_W-1:0] idx_q
);
  assign idx_next = {bit_in, idx_q[IDX_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_next;
  end

  AST_NEW_BIT_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> idx_q[IDX_W-1] == $past(bit_in)); // R2
  AST_OLD_BITS_MOVE_DOWN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> idx_q[IDX_W-2:0] == $past(idx_q[IDX_W-1:1])); // R2
endmodule

// File: rtl/sfd_flip_decoder.sv
module sfd_flip_decoder #(
  parameter int SLICE_W = 8,
  localparam int IDX_W = $clog2(SLICE_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IDX_W-1:0]   idx,
  output logic [SLICE_W-1:0] mask
);
  for (genvar i = 0; i < SLICE_W; i++) begin : g_dec
    assign mask[i] = (idx == IDX_W'(i));
  end

  AST_MASK_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
    $countones(mask) == 1); // R3
endmodule

// File: rtl/sfd_slice_store.sv
module sfd_slice_store #(
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flip_req,
  input  logic               load,
  input  logic [SLICE_W-1:0] mask,
  output logic [SLICE_W-1:0] slice_out,
  output logic               slice_valid
);
  logic [SLICE_W-1:0] slice_q;
  logic               do_flip;

  assign do_flip = flip_req && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      slice_q     <= '0;
      slice_out   <= '0;
      slice_valid <= 1'b0;
    end else begin
      if (do_flip) slice_q <= slice_q ^ mask;
      if (load) slice_out <= slice_q;
      slice_valid <= load;
    end
  end

  AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !flip_req |=> $stable(slice_q)); // R4
  AST_HOLD_DURING_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> $stable(slice_q)); // R7
  AST_SINGLE_BIT_FLIP: assert property (@(posedge clk) disable iff (rst)
    (flip_req && !load) |=> $countones(slice_q ^ $past(slice_q)) == 1); // R3
  AST_VALID_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> slice_valid); // R6
  AST_NO_VALID_UNLOADED: assert property (@(posedge clk) disable iff (rst)
    !load |=> !slice_valid); // R6
endmodule

// File: rtl/slice_flip_decomp.sv
module slice_flip_decomp
  import slice_flip_pkg::*;
#(
  parameter int SLICE_W = 8,
  localparam int IDX_W = $clog2(SLICE_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scan_in,
  input  logic               flip_en,
  input  logic               shared_en,
  input  logic               en_src_shared,
  input  logic               load_slice,
  output logic [SLICE_W-1:0] slice_out,
  output logic               slice_valid
);
  logic [IDX_W-1:0]   idx_next;
  logic [IDX_W-1:0]   idx_q;
  logic [SLICE_W-1:0] mask;
  logic               flip_req;
  en_src_e            en_src;

  assign en_src   = en_src_e'(en_src_shared);
  assign flip_req = (en_src == EN_SRC_SHARED) ? shared_en : flip_en;

  sfd_index_shifter #(.IDX_W(IDX_W)) u_shift (
    .clk(clk), .rst(rst), .bit_in(scan_in),
    .idx_next(idx_next), .idx_q(idx_q)
  );

  sfd_flip_decoder #(.SLICE_W(SLICE_W)) u_dec (
    .clk(clk), .rst(rst), .idx(idx_next), .mask(mask)
  );

  sfd_slice_store #(.SLICE_W(SLICE_W)) u_store (
    .clk(clk), .rst(rst), .flip_req(flip_req), .load(load_slice),
    .mask(mask), .slice_out(slice_out), .slice_valid(slice_valid)
  );

  AST_UNSELECTED_PIN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (en_src_shared && !shared_en) |=> !$changed(u_store.slice_q)); // R8
endmodule

// File: tb/slice_flip_decomp_bench.sv
module slice_flip_decomp_bench;
  localparam int SLICE_W = 8;
  localparam int IDX_W = $clog2(SLICE_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_in = 1'b0, flip_en = 1'b0, shared_en = 1'b0;
  logic en_src_shared = 1'b0, load_slice = 1'b0;
  logic [SLICE_W-1:0] slice_out;
  logic slice_valid;

  int checks = 0;
  int fails = 0;
  logic [IDX_W-1:0]   m_idx = '0;
  logic [SLICE_W-1:0] m_slice = '0;
  logic [SLICE_W-1:0] m_out = '0;
  logic               m_valid = 1'b0;

  always #10 clk = ~clk;

  slice_flip_decomp #(.SLICE_W(SLICE_W)) u_slice_flip_decomp (
    .clk(clk), .rst(rst), .scan_in(scan_in), .flip_en(flip_en),
    .shared_en(shared_en), .en_src_shared(en_src_shared),
    .load_slice(load_slice), .slice_out(slice_out), .slice_valid(slice_valid)
  );

  task automatic check(input string req, input logic [SLICE_W-1:0] act,
                       input logic [SLICE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock: inputs applied here, model updated, outputs compared after negedge
  task automatic step(input string req, input logic b, input logic en,
                      input logic sh, input logic sel, input logic ld);
    logic [IDX_W-1:0] nidx;
    logic             fe;
    scan_in = b; flip_en = en; shared_en = sh; en_src_shared = sel; load_slice = ld;
    nidx = {b, m_idx[IDX_W-1:1]};
    fe = sel ? sh : en;
    m_valid = ld;
    if (ld) m_out = m_slice;
    if (fe && !ld) m_slice = m_slice ^ (SLICE_W'(1) << nidx);
    m_idx = nidx;
    @(posedge clk);
    @(negedge clk);
    check({req, " valid"}, SLICE_W'(slice_valid), SLICE_W'(m_valid));
    if (m_valid) check({req, " data"}, slice_out, m_out);
  endtask

  task automatic load_and_check(input string req);
    step(req, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step(req, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", SLICE_W'(slice_valid), '0);
    check("R1 out in reset", slice_out, '0);
    rst = 1'b0;
    load_and_check("R1 zero slice after reset");

    // R2 R3: every index reached by shifting its bits LSB first, flip on the last
    for (int t = 0; t < SLICE_W; t++) begin
      for (int k = 0; k < IDX_W; k++)
        step("R2 shift", t[k], (k == IDX_W-1), 1'b0, 1'b0, 1'b0);
      load_and_check("R3 single flip");
      for (int k = 0; k < IDX_W; k++)
        step("R9 reflip", t[k], (k == IDX_W-1), 1'b0, 1'b0, 1'b0);
      load_and_check("R9 restored");
      check("R9 slice back to zero", m_slice, '0);
    end

    // R5: from index 0, bits 1,1 with enable give flips at 4 then 6
    for (int k = 0; k < IDX_W; k++) step("R5 clear idx", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R5 first", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R5 second", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    load_and_check("R5 overlap");
    check("R5 bits 4 and 6", m_slice, 8'b0101_0000);

    // R4: shifting without enable leaves slice
    for (int k = 0; k < 6; k++) step("R4 no enable", k[0], 1'b0, 1'b0, 1'b0, 1'b0);
    load_and_check("R4 slice unchanged");
    check("R4 model", m_slice, 8'b0101_0000);

    // R7: load with enable blocks flip, index still shifts
    step("R7 load blocks flip", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    load_and_check("R7 slice unchanged");
    step("R7 shift continued", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    load_and_check("R7 index kept shifting");

    // R8: shared source selected, dedicated pin ignored, then shared pin acts
    for (int k = 0; k < 4; k++) step("R8 pin ignored", k[1], 1'b1, 1'b0, 1'b1, 1'b0);
    load_and_check("R8 dedicated ignored");
    for (int k = 0; k < 4; k++) step("R8 shared acts", k[0], 1'b0, 1'b1, 1'b1, 1'b0);
    load_and_check("R8 shared flips");
    for (int k = 0; k < 4; k++) step("R8 shared ignored", k[0], 1'b0, 1'b1, 1'b0, 1'b0);
    load_and_check("R8 shared pin ignored when unselected");

    // mixed pseudo-random run, compared every cycle
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R3 R6 random", lfsr[0], lfsr[1], lfsr[2], lfsr[3], (lfsr[7:5] == 3'd0));
    end
    load_and_check("R6 final");

    // R1 again: reset mid-run clears everything
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_idx = '0; m_slice = '0;
    check("R1 valid after reset", SLICE_W'(slice_valid), '0);
    load_and_check("R1 slice cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule